// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block divides a high-speed oscillator-rate clock down to the feedback clock of a frequency synthesizer loop. Every input edge is first halved by a fixed divide-by-two stage, and the halved rate then clocks a reloadable modulus counter. One feedback period therefore lasts twice the modulus in input clock cycles. The synthesized frequency is 2 × M × fref / N, with N being the reference predivider that sits outside this block.

In integer mode the modulus is a static integer M. In fractional mode a third-order multi-stage noise-shaping modulator adds a small signed offset to M once per feedback period. The modulator is built from three cascaded 32-bit accumulators, and its carries form a sequence whose long-run mean is the 32-bit fraction K/2^32. A fractional setting yields only an approximation of the target frequency, because it is quantized to steps of 2^-32. Settings outside the legal window raise an error flag, and the divider keeps running on the last setting that was accepted.

Top module: `fracn_fb_divider`

## Requirements
- R1: In integer mode (frac_mode = 0) every feedback period lasts exactly 2 × M input clock cycles.
- R2: In integer mode every M from 8 to 127 inclusive is accepted. M below 8 is rejected.
- R3: In fractional mode (frac_mode = 1), M is accepted only from 11 to 123 inclusive. Both 10 and 124 are rejected.
- R4: In fractional mode K is accepted only when 100 × K is strictly greater than 2^32 and strictly less than 99 × 2^32, which gives 42949673 ≤ K ≤ 4252017623. In integer mode K has no effect.
- R5: In fractional mode, the sum of the moduli over any run of consecutive periods differs from count × (M + K/2^32) by no more than 4.
- R6: In fractional mode every single period uses a modulus between M − 3 and M + 4.
- R7: param_error goes high on the first clock edge after an illegal setting is presented. While it is high, the divider keeps the last accepted mode, M and K. It goes low again on the first edge that sees a legal setting.
- R8: fb_clk rises when a new modulus is loaded. It stays high for 2 × ceil(modulus/2) input cycles of each period.
- R9: While rst_n is low, fb_clk and param_error are 0. After reset the active setting is integer mode with M = 16 until the first legal setting is accepted.
- R10: The modulus changes only at the terminal count, so each period uses a single modulator sample and no period mixes two settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | Oscillator-rate input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frac_mode | input | 1 | 0 = integer division, 1 = fractional division |
| m_div | input | 7 | Integer part of the division ratio |
| k_frac | input | 32 | Fraction numerator over 2^32 |
| fb_clk | output | 1 | Divided feedback clock |
| param_error | output | 1 | High while the presented setting is illegal |

## Verification
The bench probes both edges of each legal window: 7/8/127 in integer mode, and 10/11/123/124 in fractional mode. It also probes the values of K just inside and just outside the 1 % and 99 % bounds. A design with an off-by-one range check would either flag a legal setting or start dividing by an illegal modulus, which would show up as the wrong period length. Every illegal row is followed by a check of the period length and the long-run average, to catch a divider that loads the rejected value instead of holding the previous one. The fractional rows measure each period's length and duty cycle, and they compare the accumulated modulus sum with M + K/2^32. Such a sum drifts away at once if a carry is wired into the wrong difference term or if the prescaler is missing.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
    localparam int MOD_W_DEF  = 7;
    localparam int FRAC_W_DEF = 32;
    localparam int OFS_W_DEF  = 4;
    localparam int RST_M_DEF  = 16;

    typedef enum logic {
        DIV_INTEGER    = 1'b0,
        DIV_FRACTIONAL = 1'b1
    } div_mode_e;
endpackage

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    typedef struct packed {
        logic phase;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.phase;

    assert_tick_alternates_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/fbdiv_cfg_check.sv
module fbdiv_cfg_check
    import fbdiv_pkg::*;
#(
    parameter int MOD_W   = MOD_W_DEF,
    parameter int FRAC_W  = FRAC_W_DEF,
    parameter int RST_M   = RST_M_DEF,
    parameter int INT_MIN = 8,
    parameter int INT_MAX = 127,
    parameter int FR_MIN  = 11,
    parameter int FR_MAX  = 123
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frac_i,
    input  logic [MOD_W-1:0]  m_i,
    input  logic [FRAC_W-1:0] k_i,
    output logic              act_frac_o,
    output logic [MOD_W-1:0]  act_m_o,
    output logic [FRAC_W-1:0] act_k_o,
    output logic              err_o
);
    localparam int KW = FRAC_W + 8;
    localparam logic [KW-1:0] LO_LIM = KW'(1) << FRAC_W;
    localparam logic [KW-1:0] HI_LIM = LO_LIM * KW'(99);

    typedef struct packed {
        div_mode_e         mode;
        logic [MOD_W-1:0]  m;
        logic [FRAC_W-1:0] k;
        logic              err;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    logic [MOD_W:0] m_w;
    logic [KW-1:0]  k100;
    logic           m_int_ok, m_fr_ok, k_ok, legal;

    always_comb begin
        m_w      = {1'b0, m_i};
        k100     = KW'(k_i) * KW'(100);
        m_int_ok = (m_w >= (MOD_W+1)'(INT_MIN)) && (m_w <= (MOD_W+1)'(INT_MAX));
        m_fr_ok  = (m_w >= (MOD_W+1)'(FR_MIN))  && (m_w <= (MOD_W+1)'(FR_MAX));
        k_ok     = (k100 > LO_LIM) && (k100 < HI_LIM);
        legal    = frac_i ? (m_fr_ok && k_ok) : m_int_ok;

        st_d     = st_q;
        st_d.err = !legal;
        if (legal) begin
            st_d.mode = frac_i ? DIV_FRACTIONAL : DIV_INTEGER;
            st_d.m    = m_i;
            st_d.k    = frac_i ? k_i : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= DIV_INTEGER;
            st_q.m    <= MOD_W'(RST_M);
            st_q.k    <= '0;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_frac_o = (st_q.mode == DIV_FRACTIONAL);
    assign act_m_o    = st_q.m;
    assign act_k_o    = st_q.k;
    assign err_o      = st_q.err;

    assert_err_holds_m_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (act_m_o == $past(act_m_o)) && (act_k_o == $past(act_k_o)));

    assert_int_k_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !act_frac_o |-> (act_k_o == '0));
endmodule

// File: rtl/fbdiv_mash.sv
module fbdiv_mash
    import fbdiv_pkg::*;
#(
    parameter int FRAC_W = FRAC_W_DEF,
    parameter int OFS_W  = OFS_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_i,
    input  logic                    frac_en_i,
    input  logic [FRAC_W-1:0]       k_i,
    output logic signed [OFS_W-1:0] offset_o
);
    typedef struct packed {
        logic [FRAC_W-1:0] acc1;
        logic [FRAC_W-1:0] acc2;
        logic [FRAC_W-1:0] acc3;
        logic              c2_z;
        logic              c3_z1;
        logic              c3_z2;
    } mash_st_t;

    mash_st_t st_d, st_q;

    logic [FRAC_W:0]  s1, s2, s3;
    logic [OFS_W-1:0] y;

    always_comb begin
        s1 = {1'b0, st_q.acc1} + {1'b0, k_i};
        s2 = {1'b0, st_q.acc2} + {1'b0, s1[FRAC_W-1:0]};
        s3 = {1'b0, st_q.acc3} + {1'b0, s2[FRAC_W-1:0]};
        // third-order noise shaping: c1 + d(c2) + d2(c3)
        y  = OFS_W'(s1[FRAC_W]) + OFS_W'(s2[FRAC_W]) - OFS_W'(st_q.c2_z)
           + OFS_W'(s3[FRAC_W]) - OFS_W'({st_q.c3_z1, 1'b0}) + OFS_W'(st_q.c3_z2);
        offset_o = frac_en_i ? $signed(y) : '0;

        st_d = st_q;
        if (step_i) begin
            if (frac_en_i) begin
                st_d.acc1  = s1[FRAC_W-1:0];
                st_d.acc2  = s2[FRAC_W-1:0];
                st_d.acc3  = s3[FRAC_W-1:0];
                st_d.c2_z  = s2[FRAC_W];
                st_d.c3_z1 = s3[FRAC_W];
                st_d.c3_z2 = st_q.c3_z1;
            end else begin
                st_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_offset_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frac_en_i |-> ($signed(offset_o) >= -3) && ($signed(offset_o) <= 4));

    assert_idle_between_steps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(st_q));
endmodule

// File: rtl/fbdiv_modcounter.sv
module fbdiv_modcounter
    import fbdiv_pkg::*;
#(
    parameter int MOD_W = MOD_W_DEF,
    parameter int OFS_W = OFS_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_i,
    input  logic [MOD_W-1:0]        base_m_i,
    input  logic signed [OFS_W-1:0] offset_i,
    output logic                    load_o,
    output logic                    fb_o
);
    typedef struct packed {
        logic [MOD_W-1:0] cnt;
        logic [MOD_W-1:0] half;
        logic [MOD_W-1:0] modv;
        logic             fb;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    logic [MOD_W-1:0] ofs_ext, new_mod, cnt_dec;

    always_comb begin
        ofs_ext = {{(MOD_W-OFS_W){offset_i[OFS_W-1]}}, offset_i};
        new_mod = base_m_i + ofs_ext;
        cnt_dec = st_q.cnt - 1'b1;
        load_o  = tick_i && (st_q.cnt == '0);

        st_d = st_q;
        if (load_o) begin
            st_d.modv = new_mod;
            st_d.cnt  = new_mod - 1'b1;
            st_d.half = new_mod >> 1;
            st_d.fb   = 1'b1;
        end else if (tick_i) begin
            st_d.cnt = cnt_dec;
            st_d.fb  = (cnt_dec >= st_q.half);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fb_o = st_q.fb;

    assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    assert_mod_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_o |=> $stable(st_q.modv));

    assert_rise_at_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fb_o) |-> $past(load_o));
endmodule

// File: rtl/fracn_fb_divider.sv
module fracn_fb_divider
    import fbdiv_pkg::*;
#(
    parameter int MOD_W  = MOD_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF,
    parameter int OFS_W  = OFS_W_DEF,
    parameter int RST_M  = RST_M_DEF
) (
    input  logic              clk_vco,
    input  logic              rst_n,
    input  logic              frac_mode,
    input  logic [MOD_W-1:0]  m_div,
    input  logic [FRAC_W-1:0] k_frac,
    output logic              fb_clk,
    output logic              param_error
);
    logic                    tick;
    logic                    act_frac;
    logic [MOD_W-1:0]        act_m;
    logic [FRAC_W-1:0]       act_k;
    logic                    load;
    logic signed [OFS_W-1:0] offset;

    fbdiv_prescaler u_pre (
        .clk    (clk_vco),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    fbdiv_cfg_check #(
        .MOD_W (MOD_W),
        .FRAC_W(FRAC_W),
        .RST_M (RST_M)
    ) u_cfg (
        .clk        (clk_vco),
        .rst_n      (rst_n),
        .frac_i     (frac_mode),
        .m_i        (m_div),
        .k_i        (k_frac),
        .act_frac_o (act_frac),
        .act_m_o    (act_m),
        .act_k_o    (act_k),
        .err_o      (param_error)
    );

    fbdiv_mash #(
        .FRAC_W(FRAC_W),
        .OFS_W (OFS_W)
    ) u_mash (
        .clk       (clk_vco),
        .rst_n     (rst_n),
        .step_i    (load),
        .frac_en_i (act_frac),
        .k_i       (act_k),
        .offset_o  (offset)
    );

    fbdiv_modcounter #(
        .MOD_W(MOD_W),
        .OFS_W(OFS_W)
    ) u_cnt (
        .clk      (clk_vco),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .base_m_i (act_m),
        .offset_i (offset),
        .load_o   (load),
        .fb_o     (fb_clk)
    );
endmodule

// File: tb/tb_fracn_fb_divider.sv
module tb_fracn_fb_divider;
    localparam int CLK_PERIOD = 2;
    localparam int WATCHDOG   = 190000;

    typedef struct packed {
        logic        frac;
        logic [6:0]  m;
        logic [31:0] k;
        logic        err;
        logic        efrac;
        logic [6:0]  em;
        logic [31:0] ek;
        logic [15:0] nper;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 7'd8,   32'd0,          1'b0, 1'b0, 7'd8,   32'd0,          16'd32},
        '{1'b0, 7'd127, 32'd0,          1'b0, 1'b0, 7'd127, 32'd0,          16'd16},
        '{1'b0, 7'd7,   32'd0,          1'b1, 1'b0, 7'd127, 32'd0,          16'd8},
        '{1'b0, 7'd0,   32'd0,          1'b1, 1'b0, 7'd127, 32'd0,          16'd8},
        '{1'b1, 7'd20,  32'h8000_0000,  1'b0, 1'b1, 7'd20,  32'h8000_0000,  16'd256},
        '{1'b1, 7'd10,  32'h8000_0000,  1'b1, 1'b1, 7'd20,  32'h8000_0000,  16'd32},
        '{1'b1, 7'd124, 32'h8000_0000,  1'b1, 1'b1, 7'd20,  32'h8000_0000,  16'd32},
        '{1'b1, 7'd11,  32'd42949673,   1'b0, 1'b1, 7'd11,  32'd42949673,   16'd256},
        '{1'b1, 7'd11,  32'd42949672,   1'b1, 1'b1, 7'd11,  32'd42949673,   16'd64},
        '{1'b1, 7'd123, 32'd4252017623, 1'b0, 1'b1, 7'd123, 32'd4252017623, 16'd64},
        '{1'b1, 7'd123, 32'd4252017624, 1'b1, 1'b1, 7'd123, 32'd4252017623, 16'd16},
        '{1'b1, 7'd40,  32'd0,          1'b1, 1'b1, 7'd123, 32'd4252017623, 16'd16},
        '{1'b0, 7'd9,   32'hFFFF_FFFF,  1'b0, 1'b0, 7'd9,   32'd0,          16'd32},
        '{1'b1, 7'd33,  32'h5555_5555,  1'b0, 1'b1, 7'd33,  32'h5555_5555,  16'd256}
    };

    logic        clk_vco = 1'b0;
    logic        rst_n = 1'b0;
    logic        frac_mode = 1'b0;
    logic [6:0]  m_div = 7'd16;
    logic [31:0] k_frac = '0;
    logic        fb_clk;
    logic        param_error;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    fracn_fb_divider dut (
        .clk_vco    (clk_vco),
        .rst_n      (rst_n),
        .frac_mode  (frac_mode),
        .m_div      (m_div),
        .k_frac     (k_frac),
        .fb_clk     (fb_clk),
        .param_error(param_error)
    );

    always #(CLK_PERIOD/2) clk_vco = ~clk_vco;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic wait_rise();
        logic prev;
        bit   seen;
        prev = fb_clk;
        seen = 1'b0;
        while (!seen) begin
            @(negedge clk_vco);
            if (!prev && fb_clk) seen = 1'b1;
            prev = fb_clk;
        end
    endtask

    // Measures nper periods starting at a rising edge of fb_clk
    task automatic measure(input int nper, output longint sum_mod, output int mn,
                           output int mx, output int duty_bad);
        logic prev;
        int   cyc, hi, md;
        sum_mod = 0; mn = 1000; mx = -1000; duty_bad = 0;
        wait_rise();
        for (int p = 0; p < nper; p++) begin
            cyc = 1; hi = 1; prev = 1'b1;
            forever begin
                @(negedge clk_vco);
                if (!prev && fb_clk) break;
                prev = fb_clk;
                cyc++;
                if (fb_clk) hi++;
            end
            md = cyc / 2;
            sum_mod += md;
            if (md < mn) mn = md;
            if (md > mx) mx = md;
            if ((cyc % 2 != 0) || (hi != 2 * (md - md / 2))) duty_bad++;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk_vco);
        check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        report();
    end

    initial begin
        longint sum_mod;
        int     mn, mx, duty_bad;
        real    expv, diff;

        // R9: reset state
        repeat (4) @(negedge clk_vco);
        check(fb_clk == 1'b0, "R9", "fb_clk in reset", fb_clk, 0);
        check(param_error == 1'b0, "R9", "param_error in reset", param_error, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk_vco);
            frac_mode = VECS[i].frac;
            m_div     = VECS[i].m;
            k_frac    = VECS[i].k;
            repeat (2) @(negedge clk_vco);
            check(param_error == VECS[i].err, VECS[i].frac ? "R3/R4/R7" : "R2/R7",
                  $sformatf("param_error row %0d", i), param_error, VECS[i].err);
            wait_rise();
            wait_rise();
            measure(int'(VECS[i].nper), sum_mod, mn, mx, duty_bad);
            check(duty_bad == 0, "R8", $sformatf("duty/period shape row %0d", i),
                  duty_bad, 0);
            if (!VECS[i].efrac) begin
                // R1 R10: integer setting gives a fixed modulus
                check(mn == int'(VECS[i].em) && mx == int'(VECS[i].em), "R1",
                      $sformatf("min modulus row %0d", i), mn, VECS[i].em);
            end else begin
                check(mn >= int'(VECS[i].em) - 3 && mx <= int'(VECS[i].em) + 4, "R6",
                      $sformatf("max modulus row %0d", i), mx, VECS[i].em);
                expv = real'(VECS[i].em) + real'(longint'({32'd0, VECS[i].ek})) / 4294967296.0;
                diff = real'(sum_mod) - real'(VECS[i].nper) * expv;
                if (diff < 0.0) diff = -diff;
                check(diff <= 4.0, "R5", $sformatf("modulus sum row %0d", i), sum_mod,
                      longint'(real'(VECS[i].nper) * expv));
            end
        end

        // R9: reset mid-run with an illegal integer setting presented
        @(negedge clk_vco);
        frac_mode = 1'b1; m_div = 7'd33; k_frac = 32'h4000_0000;
        repeat (40) @(negedge clk_vco);
        rst_n = 1'b0;
        frac_mode = 1'b0; m_div = 7'd5; k_frac = '0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk_vco);
            check(fb_clk == 1'b0, "R9", "fb_clk held low in reset", fb_clk, 0);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk_vco);
        check(param_error == 1'b1, "R7", "illegal after reset flagged", param_error, 1);
        wait_rise();
        measure(8, sum_mod, mn, mx, duty_bad);
        check(mn == 16 && mx == 16, "R9", "default modulus after reset", mn, 16);

        // R7: error clears once a legal value appears
        @(negedge clk_vco);
        m_div = 7'd12;
        repeat (2) @(negedge clk_vco);
        check(param_error == 1'b0, "R7", "error clears on legal input", param_error, 0);
        wait_rise();
        wait_rise();
        measure(8, sum_mod, mn, mx, duty_bad);
        check(mn == 12 && mx == 12, "R1", "modulus after recovery", mx, 12);

        report();
    end
endmodule